// File: doc/BRIEF.md
# Retriggerable Down-Counter Timer Channel

This block is one programmable counter/timer channel controlled over a byte-wide register bus. Software stores a time constant and a mode. A rising edge on the trigger input loads the time constant into the down-counter. Each rising edge of the count-clock input then decrements it, provided the gate input allows counting. When the count passes from 1, a terminal count occurs. Depending on the mode, the counter either stops at zero or reloads and keeps running. Each terminal count raises an interrupt-pending flag. A terminal count that is missed while that flag is still set is reported later through an error flag.

The count-clock, trigger and gate inputs are asynchronous. They are synchronised to the system clock, and the counter acts on the edges it detects. Software can read the live count as two bytes. It can also freeze a snapshot so that both bytes belong to the same count value. The output pin carries either a one-cycle pulse at each terminal count or a square wave made of two countdown halves.

Register addresses:

| Address | Access | Contents |
|---|---|---|
| 0 | write | time-constant low byte |
| 1 | write | time-constant high byte |
| 2 | write | mode: bit0 continuous, bit1 retrigger enable, bit2 square wave |
| 3 | write | command: bit0 IE (value written), bit1 clear IP (write 1), bit2 freeze (write 1) |
| 3 | read | status: bit0 IE, bit1 IP, bit2 ERR, bit3 CIP, bit4 frozen |
| 4 | read | current count high byte |
| 5 | read | current count low byte |

Top module: `ctc_channel`

## Requirements
- R1: With mode bit1 at 0, a trigger edge that arrives while the count-in-progress flag (status bit3) is 1 leaves the count unchanged.
- R2: With mode bit1 at 1, every trigger edge loads the time constant into the counter and sets status bit3, even while a countdown is running.
- R3: Status bit3 becomes 1 when the counter is loaded. It becomes 0 at a terminal count in single-cycle mode (mode bit0 at 0).
- R4: Address 4 returns the count bits above bit 7 and address 5 returns the low 8 bits. While no freeze is active, both follow the live counter.
- R5: Writing 1 to command bit2 captures the count. Both count addresses then return the captured value, and status bit4 reads 1, until address 5 is read. After that read, status bit4 reads 0 and the count addresses follow the live counter again.
- R6: In single-cycle mode, the terminal count leaves the counter at 0. Further count-clock edges do not change it.
- R7: In continuous mode (mode bit0 at 1), the terminal count reloads the counter. The reload uses the time constant as last written, including a value written during the countdown.
- R8: Every terminal count sets IP (status bit1). The interrupt output is 1 exactly when IP and IE (command bit0) are both 1.
- R9: A terminal count that occurs while IP is 1 is stored internally. The next clear of IP then leaves IP at 1 and sets ERR (status bit2). Further terminal counts before that clear add nothing more.
- R10: A clear of IP when no missed terminal count is stored sets both IP and ERR to 0.
- R11: The gate input is taken while the count clock is low. A count-clock rising edge with the gate low at that time leaves the count unchanged.
- R12: In square-wave mode (mode bit2 at 1), the output is 1 during the first countdown of the time constant. It is 0 during a second countdown, which starts by a reload at the midpoint and raises no IP. A trigger with retriggering enabled returns the output to 1 and restarts the first half.
- R13: Outside square-wave mode, the output is 1 for exactly one system-clock cycle per terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cnt_clk_i | input | 1 | Asynchronous count-clock input |
| trig_i | input | 1 | Asynchronous trigger input |
| gate_i | input | 1 | Asynchronous gate input |
| wave_o | output | 1 | Pulse or square-wave output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives a retrigger into a running countdown with retriggering off and then on. A design that reloads in the first case, or ignores the trigger in the second, returns a wrong count. It rewrites the time constant in the middle of a continuous countdown. A design that reloads a stale value returns the old constant after the terminal count. It freezes the count, keeps counting, and reads the high byte before the low byte. A snapshot that is released too early or never captured returns a torn or live value. It forces three terminal counts in a row without clearing IP. A design that loses the missed terminal count, or reports an error on a clean clear, shows the wrong IP/ERR pair on the two clears that follow.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam int unsigned BUS_AW = 3;
  localparam int unsigned BUS_DW = 8;

  typedef enum logic [BUS_AW-1:0] {
    A_TCLO  = 3'd0,
    A_TCHI  = 3'd1,
    A_MODE  = 3'd2,
    A_CMD   = 3'd3,
    A_CURHI = 3'd4,
    A_CURLO = 3'd5
  } ctc_addr_e;

  // bit2 square, bit1 retrigger, bit0 continuous
  typedef struct packed {
    logic square;
    logic retrig;
    logic cont;
  } ctc_mode_t;

  localparam int unsigned CMD_IE  = 0;
  localparam int unsigned CMD_CLR = 1;
  localparam int unsigned CMD_FRZ = 2;

endpackage

// File: rtl/ctc_rst_sync.sv
module ctc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb sh_n = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ctc_edge_sync.sv
module ctc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_n;

  always_comb sh_n = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/ctc_down.sv
module ctc_down
  import ctc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tc_val,
  input  ctc_mode_t        mode,
  input  logic             trig_rise,
  input  logic             cnt_level,
  input  logic             cnt_rise,
  input  logic             gate_level,
  output logic [CNT_W-1:0] cnt,
  output logic             cip,
  output logic             gate_lat,
  output logic             load_evt,
  output logic             tc_evt,
  output logic             wave
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cip_q, cip_n;
  logic             phase_q, phase_n;
  logic             gate_q, gate_n;
  logic             wave_q, wave_n;
  logic             step;

  // gate is transparent while the count clock is low, held while high
  always_comb gate_n = cnt_level ? gate_q : gate_level;

  always_comb begin
    load_evt = trig_rise & (~cip_q | mode.retrig);
    step     = cnt_rise & gate_q & cip_q & ~load_evt;
    cnt_n    = cnt_q;
    cip_n    = cip_q;
    phase_n  = phase_q;
    tc_evt   = 1'b0;
    if (load_evt) begin
      cnt_n   = tc_val;
      cip_n   = 1'b1;
      phase_n = 1'b0;
    end else if (step) begin
      if (cnt_q == ONE) begin
        if (mode.square && !phase_q) begin
          cnt_n   = tc_val;
          phase_n = 1'b1;
        end else begin
          tc_evt  = 1'b1;
          phase_n = 1'b0;
          if (mode.cont) begin
            cnt_n = tc_val;
          end else begin
            cnt_n = '0;
            cip_n = 1'b0;
          end
        end
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
    wave_n = mode.square ? (cip_n & ~phase_n) : tc_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cip_q   <= 1'b0;
      phase_q <= 1'b0;
      gate_q  <= 1'b0;
      wave_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      cip_q   <= cip_n;
      phase_q <= phase_n;
      gate_q  <= gate_n;
      wave_q  <= wave_n;
    end
  end

  assign cnt      = cnt_q;
  assign cip      = cip_q;
  assign gate_lat = gate_q;
  assign wave     = wave_q;
endmodule

// File: rtl/ctc_irq.sv
module ctc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_evt,
  input  logic ip_clr,
  input  logic ie,
  output logic ip,
  output logic err,
  output logic err_pend,
  output logic irq
);
  logic ip_q, ip_n;
  logic err_q, err_n;
  logic pend_q, pend_n;

  always_comb begin
    ip_n   = ip_q;
    err_n  = err_q;
    pend_n = pend_q;
    if (ip_clr) begin
      ip_n   = pend_q;
      err_n  = pend_q;
      pend_n = 1'b0;
    end
    if (tc_evt) begin
      if (ip_n) pend_n = 1'b1;
      ip_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q   <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ip_q   <= ip_n;
      err_q  <= err_n;
      pend_q <= pend_n;
    end
  end

  assign ip       = ip_q;
  assign err      = err_q;
  assign err_pend = pend_q;
  assign irq      = ip_q & ie;
endmodule

// File: rtl/ctc_snap.sv
module ctc_snap #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             frz_req,
  input  logic             lo_read,
  output logic [CNT_W-1:0] cur,
  output logic             frozen
);
  logic [CNT_W-1:0] snap_q, snap_n;
  logic             frz_q, frz_n;

  always_comb begin
    snap_n = snap_q;
    frz_n  = frz_q;
    if (lo_read) frz_n = 1'b0;
    if (frz_req && !frz_q) begin
      frz_n  = 1'b1;
      snap_n = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      frz_q  <= 1'b0;
    end else begin
      snap_q <= snap_n;
      frz_q  <= frz_n;
    end
  end

  assign cur    = frz_q ? snap_q : cnt;
  assign frozen = frz_q;
endmodule

// File: rtl/ctc_regs.sv
module ctc_regs
  import ctc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              ip,
  input  logic              err,
  input  logic              cip,
  input  logic              frozen,
  input  logic [CNT_W-1:0]  cur,
  output logic [BUS_DW-1:0] rdata,
  output logic [CNT_W-1:0]  tc_val,
  output ctc_mode_t         mode,
  output logic              ie,
  output logic              ip_clr,
  output logic              frz_req,
  output logic              lo_read
);
  localparam int unsigned HI_W = CNT_W - BUS_DW;

  logic [CNT_W-1:0] tc_q, tc_n;
  ctc_mode_t        mode_q, mode_n;
  logic             ie_q, ie_n;
  logic             wr_cmd;

  always_comb begin
    tc_n   = tc_q;
    mode_n = mode_q;
    ie_n   = ie_q;
    wr_cmd = wr && (addr == A_CMD);
    if (wr && addr == A_TCLO) tc_n[BUS_DW-1:0]     = wdata;
    if (wr && addr == A_TCHI) tc_n[CNT_W-1:BUS_DW] = wdata[HI_W-1:0];
    if (wr && addr == A_MODE) mode_n = ctc_mode_t'(wdata[2:0]);
    if (wr_cmd)               ie_n   = wdata[CMD_IE];
    ip_clr  = wr_cmd & wdata[CMD_CLR];
    frz_req = wr_cmd & wdata[CMD_FRZ];
    lo_read = rd && (addr == A_CURLO);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CMD:   rdata[4:0] = {frozen, cip, err, ip, ie_q};
      A_CURHI: rdata[HI_W-1:0] = cur[CNT_W-1:BUS_DW];
      A_CURLO: rdata = cur[BUS_DW-1:0];
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q   <= '0;
      mode_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      tc_q   <= tc_n;
      mode_q <= mode_n;
      ie_q   <= ie_n;
    end
  end

  assign tc_val = tc_q;
  assign mode   = mode_q;
  assign ie     = ie_q;
endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
  import ctc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              cnt_clk_i,
  input  logic              trig_i,
  input  logic              gate_i,
  output logic              wave_o,
  output logic              irq_o
);
  logic             rst_s_n;
  logic             cnt_lvl_w, cnt_rise_w, cnt_fall_w;
  logic             trg_lvl_w, trg_rise_w, trg_fall_w;
  logic             gate_lvl_w, gate_rise_w, gate_fall_w;
  logic [CNT_W-1:0] tc_val_w, cnt_w, cur_w;
  ctc_mode_t        mode_w;
  logic             cip_w, gate_lat_w, load_w, tc_evt_w;
  logic             ie_w, ip_clr_w, frz_req_w, lo_read_w;
  logic             ip_w, err_w, errp_w, frozen_w;

  ctc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  ctc_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_s_n), .din(cnt_clk_i),
    .level(cnt_lvl_w), .rise(cnt_rise_w), .fall(cnt_fall_w)
  );

  ctc_edge_sync #(.STAGES(SYNC_STAGES)) u_trg_sync (
    .clk(clk), .rst_n(rst_s_n), .din(trig_i),
    .level(trg_lvl_w), .rise(trg_rise_w), .fall(trg_fall_w)
  );

  ctc_edge_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_s_n), .din(gate_i),
    .level(gate_lvl_w), .rise(gate_rise_w), .fall(gate_fall_w)
  );

  ctc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .ip(ip_w), .err(err_w), .cip(cip_w), .frozen(frozen_w), .cur(cur_w),
    .rdata(bus_rdata), .tc_val(tc_val_w), .mode(mode_w), .ie(ie_w),
    .ip_clr(ip_clr_w), .frz_req(frz_req_w), .lo_read(lo_read_w)
  );

  ctc_down #(.CNT_W(CNT_W)) u_down (
    .clk(clk), .rst_n(rst_s_n),
    .tc_val(tc_val_w), .mode(mode_w),
    .trig_rise(trg_rise_w), .cnt_level(cnt_lvl_w), .cnt_rise(cnt_rise_w),
    .gate_level(gate_lvl_w),
    .cnt(cnt_w), .cip(cip_w), .gate_lat(gate_lat_w),
    .load_evt(load_w), .tc_evt(tc_evt_w), .wave(wave_o)
  );

  ctc_irq u_irq (
    .clk(clk), .rst_n(rst_s_n),
    .tc_evt(tc_evt_w), .ip_clr(ip_clr_w), .ie(ie_w),
    .ip(ip_w), .err(err_w), .err_pend(errp_w), .irq(irq_o)
  );

  ctc_snap #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_s_n),
    .cnt(cnt_w), .frz_req(frz_req_w), .lo_read(lo_read_w),
    .cur(cur_w), .frozen(frozen_w)
  );
endmodule

// File: rtl/ctc_channel_chk.sv
module ctc_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tc_val,
  input logic [CNT_W-1:0] cur,
  input logic             cip,
  input logic             load_evt,
  input logic             cnt_rise,
  input logic             gate_lat,
  input logic             tc_evt,
  input logic             ip,
  input logic             err,
  input logic             err_pend,
  input logic             ip_clr,
  input logic             frozen
);
  AST_LOAD_SETS_CIP: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cip && cnt == $past(tc_val))); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cip && !load_evt) |=> $stable(cnt)); // R6

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rise && !gate_lat && !load_evt) |=> $stable(cnt)); // R11

  AST_TC_SETS_IP: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> ip); // R8

  AST_ERR_FORCES_IP: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_clr && err_pend) |=> (ip && err)); // R9

  AST_ERR_NEEDS_IP: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ip); // R10

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (!frozen || $stable(cur))); // R5
endmodule

bind ctc_channel ctc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .cnt(cnt_w), .tc_val(tc_val_w), .cur(cur_w),
  .cip(cip_w), .load_evt(load_w), .cnt_rise(cnt_rise_w), .gate_lat(gate_lat_w),
  .tc_evt(tc_evt_w), .ip(ip_w), .err(err_w), .err_pend(errp_w),
  .ip_clr(ip_clr_w), .frozen(frozen_w)
);

// File: tb/sim_ctc_channel.sv
`timescale 1ns/1ps
module sim_ctc_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_clk_i = 1'b0, trig_i = 1'b0, gate_i = 1'b1;
  logic       wave_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int pulse_seen = 0;
  bit pulse_on = 1'b0;

  always #5 clk = ~clk;

  ctc_channel u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_clk_i(cnt_clk_i), .trig_i(trig_i), .gate_i(gate_i),
    .wave_o(wave_o), .irq_o(irq_o)
  );

  // {tc[15:0], mode[2:0], pulses[7:0], exp_count[15:0], exp_cip}
  localparam int NV = 6;
  localparam logic [43:0] VEC [NV] = '{
    {16'd10,    3'd2, 8'd3, 16'd7,     1'b1},
    {16'd5,     3'd2, 8'd5, 16'd0,     1'b0},
    {16'd5,     3'd2, 8'd7, 16'd0,     1'b0},
    {16'd4,     3'd3, 8'd4, 16'd4,     1'b1},
    {16'd4,     3'd3, 8'd6, 16'd2,     1'b1},
    {16'h0102,  3'd2, 8'd2, 16'h0100,  1'b1}
  };

  always @(negedge clk) if (pulse_on && wave_o) pulse_seen++;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    rd(3'd4, h);
    rd(3'd5, l);
    v = {h, l};
  endtask

  task automatic rd_stat(output logic [7:0] s);
    rd(3'd3, s);
  endtask

  task automatic set_tc(input logic [15:0] t);
    wr(3'd0, t[7:0]);
    wr(3'd1, t[15:8]);
  endtask

  task automatic cpulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) cnt_clk_i = 1'b1;
      repeat (4) @(negedge clk);
      cnt_clk_i = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic trigger();
    @(negedge clk) trig_i = 1'b1;
    repeat (4) @(negedge clk);
    trig_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  s, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd_stat(s);  check("R3 reset status", s, 8'h00);
    rd_cnt(v);   check("R4 reset count", v, 16'h0000);
    check("R8 reset irq", irq_o, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      set_tc(VEC[i][43:28]);
      wr(3'd2, {5'd0, VEC[i][27:25]});
      trigger();
      cpulse(int'(VEC[i][24:17]));
      rd_cnt(v);
      check("R4/R6/R7 vector count", v, int'(VEC[i][16:1]));
      rd_stat(s);
      check("R3 vector cip", s[3], int'(VEC[i][0]));
    end

    // gate
    set_tc(16'd9); wr(3'd2, 8'h02); trigger();
    gate_i = 1'b0; repeat (6) @(negedge clk);
    cpulse(3);
    rd_cnt(v); check("R11 gate low holds", v, 9);
    gate_i = 1'b1; repeat (6) @(negedge clk);
    cpulse(2);
    rd_cnt(v); check("R11 gate high counts", v, 7);

    // retrigger disabled / enabled
    set_tc(16'd8); wr(3'd2, 8'h00); trigger();
    rd_cnt(v); check("R1 trigger ignored", v, 7);
    wr(3'd2, 8'h02); cpulse(1); trigger();
    rd_cnt(v); check("R2 retrigger reloads", v, 8);

    // freeze
    set_tc(16'h1234); trigger(); cpulse(4);
    wr(3'd3, 8'h04); cpulse(2);
    rd_stat(s); check("R5 frozen flag", s[4], 1);
    rd(3'd4, b); check("R5 frozen high", b, 8'h12);
    rd(3'd5, b); check("R5 frozen low", b, 8'h30);
    rd_stat(s); check("R5 released", s[4], 0);
    rd(3'd5, b); check("R5 live low", b, 8'h2E);

    // continuous takes new constant
    set_tc(16'd3); wr(3'd2, 8'h03); trigger(); cpulse(1);
    wr(3'd0, 8'd6); cpulse(2);
    rd_cnt(v); check("R7 new constant on reload", v, 6);

    // square wave
    set_tc(16'd3); wr(3'd2, 8'h06); trigger();
    check("R12 first half high", wave_o, 1);
    cpulse(3);
    check("R12 second half low", wave_o, 0);
    rd_cnt(v); check("R12 midpoint reload", v, 3);
    cpulse(1); trigger();
    check("R12 retrigger restarts high", wave_o, 1);
    cpulse(6);
    rd_stat(s); check("R12 sequence ends", s[3], 0);
    check("R12 output low at end", wave_o, 0);

    // flush interrupt state
    wr(3'd3, 8'h02); wr(3'd3, 8'h02);
    rd_stat(s); check("R10 flushed", s[2:1], 0);

    // pulse output and IP
    set_tc(16'd2); wr(3'd2, 8'h02); wr(3'd3, 8'h01);
    pulse_on = 1'b1; trigger(); cpulse(2); repeat (4) @(negedge clk);
    pulse_on = 1'b0;
    check("R13 one pulse per terminal count", pulse_seen, 1);
    rd_stat(s); check("R8 IP set", s[1], 1);
    check("R8 irq asserted", irq_o, 1);

    // missed terminal counts
    trigger(); cpulse(2); trigger(); cpulse(2);
    wr(3'd3, 8'h03);
    rd_stat(s); check("R9 forced IP and ERR", s[2:0], 3'b111);
    wr(3'd3, 8'h03);
    rd_stat(s); check("R10 clean clear", s[2:0], 3'b001);
    check("R8 irq released", irq_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule